// File: doc/BRIEF.md
# Tiled Address Channel Swizzle Unit

On a dual-channel interleaved memory, the graphics engine picks its channel for a tiled surface from more address bits than the processor does. This unit turns a linear byte address into the address the processor must use so that its accesses land where the graphics engine expects them. Only bit 6 of the address changes. It becomes the XOR of itself with a set of higher bits. That set depends on the tiling direction (X or Y) and on the decoded channel configuration.

A configuration strobe latches one swizzle mode for X and one for Y. Each mode comes from one of two sources:
- a memory-controller configuration word, or
- an equality test between the two channels' rank-boundary values.

After that, every valid access is translated with a latency of one cycle. The unit reports the swizzle code that software may see. In that code the bit-17 contribution is folded away. A tiling-disable flag is raised when a tiled access meets a configuration that cannot be swizzled. That access then passes through untouched.

Mode codes, on 3 bits: 0 none, 1 bit 9, 2 bits 9+10, 3 bits 9+11, 4 bits 9+10+11, 5 bits 9+17, 6 bits 9+10+17, 7 unknown.

Tiling codes on `in_tile`: 0 untiled, 1 X, 2 Y, 3 treated as untiled.

Configuration word fields:
- bits [1:0] select the addressing arrangement: 0 single channel, 1 asymmetric dual, 2 interleaved dual, 3 reserved.
- bit 4 set disables channel XOR randomization.
- bit 5 set selects bit 17 (rather than bit 11) as the randomization bit.

Top module: `chan_swizzle`

## Requirements
- R1: With the word source in the interleaved arrangement and randomization disabled (bit 4 = 1), an X access gets out bit 6 = a6^a9^a10 and reports code 2.
- R2: Under the same configuration as R1, a Y access gets out bit 6 = a6^a9 and reports code 1.
- R3: In the interleaved arrangement with randomization enabled (bit 4 = 0) and bit 5 = 0, bit 11 is also XORed in. X reports code 4 and Y reports code 3.
- R4: In the interleaved arrangement with randomization enabled and bit 5 = 1, bit 17 is XORed in instead of bit 11. The reported codes are 2 for X and 1 for Y, so the bit-17 part is hidden.
- R5: The single-channel, asymmetric and reserved arrangements (bits [1:0] = 0, 1, 3) apply no swizzle for X or Y. They report code 0.
- R6: A configuration word of all ones yields the unknown mode. A tiled access then passes unchanged, reports code 0 and raises `out_untiled`.
- R7: With the rank source (`cfg_src` = 1), unequal boundaries give no swizzle (code 0). Equal boundaries give the R1/R2 swizzles and codes.
- R8: An untiled access (tile code 0 or 3) passes the address unchanged, reports code 0 and keeps `out_untiled` low, whatever the configuration.
- R9: Every address bit other than bit 6 passes unchanged. Results appear one cycle after a valid input, with `out_valid` following `in_valid` by one cycle.
- R10: The modes change only on a clock edge with `cfg_load` high. After reset both modes are unknown, so tiled accesses are flagged until a configuration is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Latch decoded X/Y modes this cycle |
| cfg_src | input | 1 | 0: configuration word, 1: rank comparison |
| cfg_word | input | CW | Memory-controller configuration word |
| rank_a | input | RW | Channel A rank boundary |
| rank_b | input | RW | Channel B rank boundary |
| in_valid | input | 1 | Access address valid |
| in_addr | input | AW | Linear byte address |
| in_tile | input | 2 | Tiling: 0 none, 1 X, 2 Y, 3 none |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | AW | Swizzled address |
| out_mode | output | 3 | Reported swizzle code |
| out_untiled | output | 1 | Tiled access forced untiled |

## Verification
Some properties are checked on every cycle:
- every bit except bit 6 of a result matches the address from the cycle before;
- the reported code never shows a bit-17 variant or unknown;
- a flagged or untiled result leaves bit 6 untouched and reports code 0.

Other behaviour needs the bench's directed scenarios:
- which higher bits each decoded configuration folds into bit 6;
- the rank-equality path;
- that configuration changes without a strobe are ignored.

// File: rtl/chan_swizzle.sv
module chan_swizzle #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int RW = 16,
  parameter int ARR_LSB = 0,
  parameter int XDIS_BIT = 4,
  parameter int SEL17_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_src,
  input  logic [CW-1:0] cfg_word,
  input  logic [RW-1:0] rank_a,
  input  logic [RW-1:0] rank_b,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_tile,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [2:0]    out_mode,
  output logic          out_untiled
);
  localparam logic [2:0] M_NONE = 3'd0, M_9 = 3'd1, M_9_10 = 3'd2, M_9_11 = 3'd3,
                         M_9_10_11 = 3'd4, M_9_17 = 3'd5, M_9_10_17 = 3'd6, M_UNK = 3'd7;
  localparam logic [AW-1:0] BIT6 = AW'(1) << 6;

  initial if (AW < 18) $error("chan_swizzle: AW must cover bit 17");

  logic [2:0] dec_x, dec_y, mode_x, mode_y, sel, use_mode, rep_mode;
  logic       tiled, unk, flip;

  always_comb begin
    dec_x = M_NONE;
    dec_y = M_NONE;
    if (cfg_src) begin
      if (rank_a == rank_b) begin
        dec_x = M_9_10;
        dec_y = M_9;
      end
    end else if (&cfg_word) begin
      dec_x = M_UNK;
      dec_y = M_UNK;
    end else if (cfg_word[ARR_LSB +: 2] == 2'd2) begin
      if (cfg_word[XDIS_BIT]) begin
        dec_x = M_9_10;
        dec_y = M_9;
      end else if (!cfg_word[SEL17_BIT]) begin
        dec_x = M_9_10_11;
        dec_y = M_9_11;
      end else begin
        dec_x = M_9_10_17;
        dec_y = M_9_17;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_x <= M_UNK;
      mode_y <= M_UNK;
    end else if (cfg_load) begin
      mode_x <= dec_x;
      mode_y <= dec_y;
    end

  assign tiled    = (in_tile == 2'd1) || (in_tile == 2'd2);
  assign sel      = (in_tile == 2'd2) ? mode_y : mode_x;
  assign unk      = tiled && (sel == M_UNK);
  assign use_mode = (tiled && !unk) ? sel : M_NONE;

  always_comb begin
    case (use_mode)
      M_9:       flip = in_addr[9];
      M_9_10:    flip = in_addr[9] ^ in_addr[10];
      M_9_11:    flip = in_addr[9] ^ in_addr[11];
      M_9_10_11: flip = in_addr[9] ^ in_addr[10] ^ in_addr[11];
      M_9_17:    flip = in_addr[9] ^ in_addr[17];
      M_9_10_17: flip = in_addr[9] ^ in_addr[10] ^ in_addr[17];
      default:   flip = 1'b0;
    endcase
    case (use_mode)
      M_9_17:    rep_mode = M_9;
      M_9_10_17: rep_mode = M_9_10;
      default:   rep_mode = use_mode;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_mode    <= M_NONE;
      out_untiled <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr    <= in_addr ^ (flip ? BIT6 : '0);
        out_mode    <= rep_mode;
        out_untiled <= unk;
      end
    end

  p_other_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_addr ^ $past(in_addr)) & ~BIT6) == '0);
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  p_hidden17_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mode <= M_9_10_11);
  p_flag_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_untiled) |-> (out_mode == M_NONE && out_addr == $past(in_addr)));
  p_untiled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !tiled) |=> (out_mode == M_NONE && !out_untiled && out_addr == $past(in_addr)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_load) |-> ($stable(mode_x) && $stable(mode_y)));
endmodule

// File: tb/chan_swizzle_test.sv
module chan_swizzle_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_load = 0, cfg_src = 0;
  logic [31:0] cfg_word = 0;
  logic [15:0] rank_a = 0, rank_b = 0;
  logic        in_valid = 0;
  logic [31:0] in_addr = 0;
  logic [1:0]  in_tile = 0;
  logic        out_valid, out_untiled;
  logic [31:0] out_addr;
  logic [2:0]  out_mode;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chan_swizzle uut (.clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src),
    .cfg_word(cfg_word), .rank_a(rank_a), .rank_b(rank_b), .in_valid(in_valid),
    .in_addr(in_addr), .in_tile(in_tile), .out_valid(out_valid), .out_addr(out_addr),
    .out_mode(out_mode), .out_untiled(out_untiled));

  function automatic logic [31:0] mk(int i);
    logic [31:0] a = 32'h5A5A_1234 & ~32'h0002_0E40;
    a[6] = i[4]; a[9] = i[0]; a[10] = i[1]; a[11] = i[2]; a[17] = i[3];
    return a;
  endfunction

  function automatic logic model_flip(logic [31:0] a, int xs, int ys);
    return a[9] ^ (xs ? a[10] : 1'b0) ^ (ys == 11 ? a[11] : 1'b0) ^ (ys == 17 ? a[17] : 1'b0);
  endfunction

  task automatic chk(string tag, logic [31:0] ea, logic [2:0] em, logic ef);
    nvec++;
    if (out_valid !== 1'b1 || out_addr !== ea || out_mode !== em || out_untiled !== ef) begin
      nerr++;
      $display("FAIL %s: got v=%b a=%h m=%0d f=%b, exp v=1 a=%h m=%0d f=%b",
               tag, out_valid, out_addr, out_mode, out_untiled, ea, em, ef);
    end
  endtask

  task automatic access(logic [31:0] a, logic [1:0] t);
    @(negedge clk); in_addr = a; in_tile = t; in_valid = 1;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic load_word(logic [31:0] w);
    @(negedge clk); cfg_src = 0; cfg_word = w; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic load_rank(logic [15:0] a, logic [15:0] b);
    @(negedge clk); cfg_src = 1; rank_a = a; rank_b = b; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  // sweep X and Y; xuse/yuse: 0 none, else add bit 10 (X) and extra bit (0/11/17)
  task automatic sweep(string tag, bit sw, int extra, logic [2:0] mx, logic [2:0] my);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] a = mk(i);
      logic [31:0] e;
      access(a, 2'd1);
      e = a; if (sw) e[6] = a[6] ^ model_flip(a, 1, extra);
      chk({tag, " X"}, e, mx, 1'b0);
      access(a, 2'd2);
      e = a; if (sw) e[6] = a[6] ^ model_flip(a, 0, extra);
      chk({tag, " Y"}, e, my, 1'b0);
    end
  endtask

  task automatic t_reset;
    nvec++;
    if (out_valid !== 0 || out_addr !== 0) begin
      nerr++; $display("FAIL R10 reset outputs: v=%b a=%h exp 0 0", out_valid, out_addr);
    end
    access(32'h0000_0640, 2'd1); chk("R10 reset unknown X", 32'h0000_0640, 3'd0, 1'b1);
    access(32'h0000_0240, 2'd2); chk("R10 reset unknown Y", 32'h0000_0240, 3'd0, 1'b1);
  endtask

  task automatic t_word;
    load_word(32'h0000_0012); sweep("R1 R2 xor-disabled", 1, 0, 3'd2, 3'd1);
    load_word(32'h0000_0002); sweep("R3 bit11", 1, 11, 3'd4, 3'd3);
    load_word(32'h0000_0022); sweep("R4 bit17", 1, 17, 3'd2, 3'd1);
    load_word(32'h0000_0000); sweep("R5 single", 0, 0, 3'd0, 3'd0);
    load_word(32'h0000_0031); sweep("R5 asym", 0, 0, 3'd0, 3'd0);
    load_word(32'h0000_0003); sweep("R5 reserved", 0, 0, 3'd0, 3'd0);
  endtask

  task automatic t_unknown;
    load_word(32'hFFFF_FFFF);
    access(mk(7), 2'd1); chk("R6 all-ones X", mk(7), 3'd0, 1'b1);
    access(mk(9), 2'd2); chk("R6 all-ones Y", mk(9), 3'd0, 1'b1);
  endtask

  task automatic t_rank;
    load_rank(16'h0040, 16'h0041); sweep("R7 unequal", 0, 0, 3'd0, 3'd0);
    load_rank(16'h0080, 16'h0080); sweep("R7 equal", 1, 0, 3'd2, 3'd1);
  endtask

  task automatic t_untiled;
    load_word(32'h0000_0022);
    for (int i = 0; i < 32; i += 5) begin
      access(mk(i), 2'd0); chk("R8 tile none", mk(i), 3'd0, 1'b0);
      access(mk(i), 2'd3); chk("R8 tile code 3", mk(i), 3'd0, 1'b0);
    end
  endtask

  task automatic t_hold_latency;
    logic [31:0] a = mk(3);
    logic [31:0] e = a;
    load_word(32'h0000_0012);
    @(negedge clk); cfg_word = 32'h0000_0000; cfg_src = 1; rank_a = 1; rank_b = 2;
    e[6] = a[6] ^ a[9] ^ a[10];
    access(a, 2'd1); chk("R10 no strobe keeps mode", e, 3'd2, 1'b0);
    @(negedge clk); nvec++;
    if (out_valid !== 1'b0) begin
      nerr++; $display("FAIL R9 out_valid after idle: got %b exp 0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_word; t_unknown; t_rank; t_untiled; t_hold_latency;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1; nvec++; nerr++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule